// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block gives a multi-function I/O chip its configuration space. Software reaches it through two byte ports. The first is an index port that holds a register pointer. The second is a data port that reads or writes the register the pointer names. The space stays locked until a key byte arrives on the index port. A second key byte locks it again. While it is locked, nothing can be changed and every read returns all ones.

A global logical-device register chooses which function's register bank the data port reaches. Each bank holds the following fields:

- a 16-bit I/O base address, written as two bytes
- two interrupt line numbers
- a DMA channel
- two device-specific mode bytes
- an enable bit

Every bank is exported as a set of configuration outputs. The floppy, serial, parallel and keyboard functions that use these outputs sit outside this block. A global read-only register returns a fixed chip identifier.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, every bank field and every `dev_active` bit is zero, the pointer and logical-device register are zero, and `cfg_rdata` reads 0xFF.
- R2: While locked, only an index-port write (`cfg_addr`=0) of 0x55 unlocks. Every other write leaves the space locked and changes no register, and `cfg_rdata` is 0xFF on both ports.
- R3: While unlocked, an index-port write of 0xAA locks the space and leaves the pointer unchanged. Any other index-port write loads the pointer.
- R4: While unlocked, a read of the index port returns the pointer. A data-port access (`cfg_addr`=1) reads or writes the register named by the pointer.
- R5: Index 0x20 reads 0x40 on the data port, and writes to it are ignored.
- R6: Index 0x07 is a read/write logical-device register that picks the bank. When it holds a value of 8 or more, bank indices read 0x00 and writes to them are ignored.
- R7: Bank index 0x60 holds the base-address high byte and 0x61 the low byte. `dev_base[n]` is {high, low}.
- R8: Bank index 0x70 drives `dev_irq_a[n]`, 0x72 drives `dev_irq_b[n]`, and 0x74 drives `dev_dma[n]`.
- R9: Bank index 0x30 stores only data bit 0 and reads back as {7'b0, bit}. `dev_active[n]` is high exactly when that bit is set.
- R10: Bank index 0xF0 drives `dev_mode_a[n]` and 0xF1 drives `dev_mode_b[n]`.
- R11: Indices that are not implemented read 0x00 on the data port, and writes to them change no output.
- R12: A write takes effect at the rising clock edge that samples `cfg_wr`. `cfg_rdata` is combinational from `cfg_addr` and the register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 1 | 0 selects the index port, 1 the data port |
| cfg_wr | input | 1 | Write strobe for the selected port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the selected port |
| dev_active | output | NUM_DEV | Per-device enable |
| dev_base | output | NUM_DEV x 16 | Per-device I/O base address |
| dev_irq_a | output | NUM_DEV x 8 | Per-device primary interrupt number |
| dev_irq_b | output | NUM_DEV x 8 | Per-device secondary interrupt number |
| dev_dma | output | NUM_DEV x 8 | Per-device DMA channel |
| dev_mode_a | output | NUM_DEV x 8 | Per-device first mode byte |
| dev_mode_b | output | NUM_DEV x 8 | Per-device second mode byte |

## Verification
The bench writes while locked, including data-port writes of 0x55. A design that unlocks on the wrong port or lets locked writes through would change outputs or stop reading 0xFF. It relocks and then unlocks again to confirm that the pointer survives, which catches a design that treats the lock key as a pointer load. It selects logical devices beyond the last bank and targets unimplemented indices, where an unchecked bank index would alias onto a real bank or read stale data. It writes the enable register with stray high bits, which a design that stores the whole byte would read back wrongly.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam logic [7:0] IDX_LDN    = 8'h07;
   localparam logic [7:0] IDX_ID     = 8'h20;
   localparam logic [7:0] IDX_ACT    = 8'h30;
   localparam logic [7:0] IDX_BASE_H = 8'h60;
   localparam logic [7:0] IDX_BASE_L = 8'h61;
   localparam logic [7:0] IDX_IRQ_A  = 8'h70;
   localparam logic [7:0] IDX_IRQ_B  = 8'h72;
   localparam logic [7:0] IDX_DMA    = 8'h74;
   localparam logic [7:0] IDX_MODE_A = 8'hF0;
   localparam logic [7:0] IDX_MODE_B = 8'hF1;

   typedef struct packed {
      logic       act;
      logic [7:0] base_h;
      logic [7:0] base_l;
      logic [7:0] irq_a;
      logic [7:0] irq_b;
      logic [7:0] dma;
      logic [7:0] mode_a;
      logic [7:0] mode_b;
   } dev_cfg_t;
endpackage

// File: rtl/sio_cfg_front.sv
module sio_cfg_front
   import sio_cfg_pkg::*;
#(
   parameter logic [7:0] KEY_OPEN  = 8'h55,
   parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       addr,
   input  logic [7:0] wdata,
   output logic       unlocked,
   output logic [7:0] ptr,
   output logic [7:0] ldn,
   output logic       data_wr
);
   logic idx_wr;
   assign idx_wr  = wr_en && !addr;
   assign data_wr = wr_en && addr && unlocked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         ptr      <= '0;
         ldn      <= '0;
      end else begin
         if (!unlocked) begin
            if (idx_wr && wdata == KEY_OPEN) unlocked <= 1'b1;
         end else if (idx_wr) begin
            if (wdata == KEY_CLOSE) unlocked <= 1'b0;
            else                    ptr      <= wdata;
         end
         if (data_wr && ptr == IDX_LDN) ldn <= wdata;
      end
   end

   // R2: a locked space opens only on the key at the index port
   a_r2_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && !(idx_wr && wdata == KEY_OPEN)) |=> (!unlocked && $stable(ptr) && $stable(ldn)));
   a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && idx_wr && wdata == KEY_OPEN) |=> unlocked);
   // R3: the close key locks without touching the pointer
   a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && idx_wr && wdata == KEY_CLOSE) |=> (!unlocked && $stable(ptr)));
   // R6: the device select moves only on a data write at its index
   a_r6_ldn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_wr && ptr == IDX_LDN) |=> $stable(ldn));
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
   import sio_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output logic [7:0] rdat,
   output dev_cfg_t   cfg
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         case (idx)
            IDX_ACT:    cfg.act    <= wdata[0];
            IDX_BASE_H: cfg.base_h <= wdata;
            IDX_BASE_L: cfg.base_l <= wdata;
            IDX_IRQ_A:  cfg.irq_a  <= wdata;
            IDX_IRQ_B:  cfg.irq_b  <= wdata;
            IDX_DMA:    cfg.dma    <= wdata;
            IDX_MODE_A: cfg.mode_a <= wdata;
            IDX_MODE_B: cfg.mode_b <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IDX_ACT:    rdat = {7'b0, cfg.act};
         IDX_BASE_H: rdat = cfg.base_h;
         IDX_BASE_L: rdat = cfg.base_l;
         IDX_IRQ_A:  rdat = cfg.irq_a;
         IDX_IRQ_B:  rdat = cfg.irq_b;
         IDX_DMA:    rdat = cfg.dma;
         IDX_MODE_A: rdat = cfg.mode_a;
         IDX_MODE_B: rdat = cfg.mode_b;
         default:    rdat = 8'h00;
      endcase
   end

   // R9: the enable bit changes only on a write to its index
   a_r9_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && idx == IDX_ACT) |=> $stable(cfg.act));
   // R11: without a write strobe the bank holds every field
   a_r11_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int         NUM_DEV   = 8,
   parameter logic [7:0] DEV_ID    = 8'h40,
   parameter logic [7:0] KEY_OPEN  = 8'h55,
   parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_addr,
   input  logic                          cfg_wr,
   input  logic [7:0]                    cfg_wdata,
   output logic [7:0]                    cfg_rdata,
   output logic [NUM_DEV-1:0]            dev_active,
   output logic [NUM_DEV-1:0][15:0]      dev_base,
   output logic [NUM_DEV-1:0][7:0]       dev_irq_a,
   output logic [NUM_DEV-1:0][7:0]       dev_irq_b,
   output logic [NUM_DEV-1:0][7:0]       dev_dma,
   output logic [NUM_DEV-1:0][7:0]       dev_mode_a,
   output logic [NUM_DEV-1:0][7:0]       dev_mode_b
);
   localparam int         LDN_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
   localparam logic [8:0] DEV_CNT = 9'(NUM_DEV);

   initial begin
      if (NUM_DEV < 1 || NUM_DEV > 256)
         $error("NUM_DEV must lie in 1..256");
      if (KEY_OPEN == KEY_CLOSE)
         $error("open and close keys must differ");
   end

   logic       unlocked;
   logic [7:0] ptr;
   logic [7:0] ldn;
   logic       data_wr;
   logic       ldn_ok;

   sio_cfg_front #(.KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .unlocked (unlocked),
      .ptr      (ptr),
      .ldn      (ldn),
      .data_wr  (data_wr)
   );

   assign ldn_ok = ({1'b0, ldn} < DEV_CNT);

   logic [NUM_DEV-1:0][7:0] bank_rd;
   dev_cfg_t                bank_cfg [NUM_DEV];

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
      logic sel_wr;
      assign sel_wr = data_wr && (ldn == 8'(i));
      sio_cfg_bank u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (sel_wr),
         .idx   (ptr),
         .wdata (cfg_wdata),
         .rdat  (bank_rd[i]),
         .cfg   (bank_cfg[i])
      );
      assign dev_active[i] = bank_cfg[i].act;
      assign dev_base[i]   = {bank_cfg[i].base_h, bank_cfg[i].base_l};
      assign dev_irq_a[i]  = bank_cfg[i].irq_a;
      assign dev_irq_b[i]  = bank_cfg[i].irq_b;
      assign dev_dma[i]    = bank_cfg[i].dma;
      assign dev_mode_a[i] = bank_cfg[i].mode_a;
      assign dev_mode_b[i] = bank_cfg[i].mode_b;
   end

   always_comb begin
      if (!unlocked)          cfg_rdata = 8'hFF;
      else if (!cfg_addr)     cfg_rdata = ptr;
      else if (ptr == IDX_LDN) cfg_rdata = ldn;
      else if (ptr == IDX_ID)  cfg_rdata = DEV_ID;
      else if (ldn_ok)        cfg_rdata = bank_rd[ldn[LDN_W-1:0]];
      else                    cfg_rdata = 8'h00;
   end

   // R2: a locked space reads all ones on either port
   a_r2_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> cfg_rdata == 8'hFF);
   // R5: identifier index returns the fixed value
   a_r5_dev_id: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && cfg_addr && ptr == IDX_ID) |-> cfg_rdata == DEV_ID);
   // R2: while locked, no enable bit can rise
   a_r2_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(dev_active));
endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
   localparam int ND = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cfg_addr = 1'b0;
   logic                 cfg_wr = 1'b0;
   logic [7:0]           cfg_wdata = '0;
   logic [7:0]           cfg_rdata;
   logic [ND-1:0]        dev_active;
   logic [ND-1:0][15:0]  dev_base;
   logic [ND-1:0][7:0]   dev_irq_a, dev_irq_b, dev_dma, dev_mode_a, dev_mode_b;

   always #4 clk = ~clk;

   sio_cfg_port #(.NUM_DEV(ND)) u_sio_cfg_port (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_active(dev_active),
      .dev_base(dev_base), .dev_irq_a(dev_irq_a), .dev_irq_b(dev_irq_b),
      .dev_dma(dev_dma), .dev_mode_a(dev_mode_a), .dev_mode_b(dev_mode_b)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model: slot 0 enable, 1 base hi, 2 base lo, 3 irq a, 4 irq b, 5 dma, 6 mode a, 7 mode b
   bit         m_unl;
   logic [7:0] m_ptr, m_ldn;
   logic [7:0] m_reg [ND][8];

   function automatic int slot_of(logic [7:0] idx);
      case (idx)
         8'h30: return 0; 8'h60: return 1; 8'h61: return 2; 8'h70: return 3;
         8'h72: return 4; 8'h74: return 5; 8'hF0: return 6; 8'hF1: return 7;
         default: return -1;
      endcase
   endfunction

   function automatic logic [7:0] model_read(logic a);
      int s;
      if (!m_unl) return 8'hFF;
      if (!a) return m_ptr;
      if (m_ptr == 8'h07) return m_ldn;
      if (m_ptr == 8'h20) return 8'h40;
      s = slot_of(m_ptr);
      if (s >= 0 && m_ldn < ND) return m_reg[m_ldn][s];
      return 8'h00;
   endfunction

   task automatic model_write(logic a, logic [7:0] d);
      int s;
      if (!m_unl) begin
         if (!a && d == 8'h55) m_unl = 1;
         return;
      end
      if (!a) begin
         if (d == 8'hAA) m_unl = 0; else m_ptr = d;
         return;
      end
      if (m_ptr == 8'h07) m_ldn = d;
      else if (m_ptr != 8'h20) begin
         s = slot_of(m_ptr);
         if (s >= 0 && m_ldn < ND) m_reg[m_ldn][s] = (s == 0) ? (d & 8'h01) : d;
      end
   endtask

   task automatic model_reset();
      m_unl = 0; m_ptr = 0; m_ldn = 0;
      for (int i = 0; i < ND; i++) for (int s = 0; s < 8; s++) m_reg[i][s] = 0;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called just after a falling edge; write lands on the next rising edge (R12)
   task automatic wr(logic a, logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(posedge clk);
      model_write(a, d);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_check(string req, logic a);
      cfg_addr = a;
      #1;
      check(req, cfg_rdata, model_read(a));
   endtask

   task automatic out_check();
      for (int i = 0; i < ND; i++) begin
         check("R9 dev_active", dev_active[i], m_reg[i][0][0]);
         check("R7 dev_base", dev_base[i], {m_reg[i][1], m_reg[i][2]});
         check("R8 irq/dma", {dev_irq_a[i], dev_irq_b[i], dev_dma[i]},
               {m_reg[i][3], m_reg[i][4], m_reg[i][5]});
         check("R10 mode", {dev_mode_a[i], dev_mode_b[i]}, {m_reg[i][6], m_reg[i][7]});
      end
   endtask

   function automatic logic [7:0] pick_idx();
      logic [7:0] pool [14] = '{8'h07, 8'h20, 8'h30, 8'h60, 8'h61, 8'h70, 8'h72,
                                8'h74, 8'hF0, 8'hF1, 8'h22, 8'h31, 8'h55, 8'hAA};
      if ($urandom_range(0, 9) == 0) return 8'($urandom);
      return pool[$urandom_range(0, 13)];
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd2718));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_check("R1 rdata locked", 1'b0);
      rd_check("R1 rdata locked", 1'b1);
      check("R1 active zero", dev_active, '0);
      out_check();
      // R2 locked writes ignored, data-port key does not unlock
      wr(1'b1, 8'h55);
      rd_check("R2 data key no unlock", 1'b1);
      wr(1'b0, 8'h30); wr(1'b1, 8'h01);
      rd_check("R2 still locked", 1'b0);
      check("R2 no enable while locked", dev_active, '0);
      wr(1'b0, 8'h55);
      rd_check("R2 unlocked pointer", 1'b0);
      check("R2 unlocked", cfg_rdata, 8'h00);
      // R5 identifier, write ignored
      wr(1'b0, 8'h20); wr(1'b1, 8'h13);
      rd_check("R5 id", 1'b1);
      check("R5 id value", cfg_rdata, 8'h40);
      // R6/R7/R8/R9 program device 4
      wr(1'b0, 8'h07); wr(1'b1, 8'h04);
      rd_check("R6 ldn readback", 1'b1);
      wr(1'b0, 8'h60); wr(1'b1, 8'h03);
      wr(1'b0, 8'h61); wr(1'b1, 8'hF8);
      wr(1'b0, 8'h70); wr(1'b1, 8'h04);
      wr(1'b0, 8'h30); wr(1'b1, 8'hFF);
      rd_check("R9 enable reads bit 0", 1'b1);
      check("R7 base 3F8", dev_base[4], 16'h03F8);
      check("R9 only device 4", dev_active, 8'h10);
      out_check();
      // R3 relock keeps pointer
      wr(1'b0, 8'hAA);
      rd_check("R3 locked reads FF", 1'b1);
      wr(1'b0, 8'h55);
      rd_check("R3 pointer kept", 1'b0);
      check("R3 pointer value", cfg_rdata, 8'h30);
      // R6 out-of-range device
      wr(1'b0, 8'h07); wr(1'b1, 8'h09);
      wr(1'b0, 8'h70); wr(1'b1, 8'h0C);
      rd_check("R6 range read zero", 1'b1);
      check("R6 zero", cfg_rdata, 8'h00);
      out_check();
      // R11 unimplemented index
      wr(1'b0, 8'h07); wr(1'b1, 8'h04);
      wr(1'b0, 8'h22); wr(1'b1, 8'h5A);
      rd_check("R11 unimpl zero", 1'b1);
      out_check();
      // R4 random mix
      for (int n = 0; n < 4000; n++) begin
         int k = $urandom_range(0, 9);
         if (k < 4)      wr(1'b0, pick_idx());
         else if (k < 8) begin
            logic [7:0] d = (m_ptr == 8'h07) ? 8'($urandom_range(0, 9)) : 8'($urandom);
            wr(1'b1, d);
         end else if (k == 8) wr(1'b0, 8'h55);
         else rd_check("R4 random read index", 1'b0);
         rd_check("R4 random read data", 1'b1);
         if (n % 16 == 0) out_check();
      end
      out_check();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule